// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Patcher

This block applies the corrections that a Reed-Solomon decoder reports to a 512-byte data chunk. The chunk sits in an internal dual-port byte RAM, which is loaded and read back through a simple external byte port. The code uses 9-bit symbols packed back to back across the byte stream. Each error report carries a symbol index and a 9-bit error mask. The decoder also supplies how many reports are valid and whether the chunk is beyond repair.

A single `start` pulse hands over the report count, the uncorrectable flag and four index/mask pairs. The patcher works through the valid reports from the highest-numbered one down to report 0. For each report it spends one cycle reading the two bytes under the symbol and one cycle writing them back with the mask XORed into the right bit field. While it works, `busy` is high and the external port cannot write. A one-cycle `done` pulse closes the job.

Top module: `rs_symbol_patcher`

## Requirements
- R1: Take the chunk as a bit stream in which stream bit 8b+t is bit t of byte b. A report with index n (n ≥ 1) XORs mask bit t into stream bit 9(n−1)+t, for t = 0..8, and leaves every other bit unchanged.
- R2: For a field that runs past byte 511 (index 456), only the bits inside the chunk are changed. Index 456 flips bit 7 of byte 511 by mask bit 0 and changes nothing else.
- R3: A report with index 0, or with an index of 457 or more, changes nothing.
- R4: Only reports 0 to count−1 are applied. They are processed from report count−1 down to report 0, and reports at or above the count are not used.
- R5: A count of 0, or a count above 4, modifies no byte, and `done` is still raised.
- R6: If `uncorrectable` is set at start, no byte is modified, whatever the count.
- R7: When several reports touch the same byte, all of their masks take effect, each applied on top of the result of the one before.
- R8: `done` is high for exactly one cycle. Counting the clock edge that samples `start` as edge 0, `done` is high after edge 2c, where c is the number of reports applied (0 for the no-op cases of R5 and R6).
- R9: `busy` is high from the edge that samples `start` until the edge after `done`. An external write issued while `busy` is high is ignored.
- R10: After reset, `busy` and `done` are low. While the block is idle, an external write stores `ext_wdata` at `ext_addr`, and `ext_rdata` shows the byte at `ext_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_we | input | 1 | External byte write enable (ignored while busy) |
| ext_addr | input | 9 | External byte address |
| ext_wdata | input | 8 | External write data |
| ext_rdata | output | 8 | Registered read data for ext_addr |
| start | input | 1 | Begins a patch job (sampled while idle) |
| err_count | input | 3 | Number of valid reports |
| uncorrectable | input | 1 | Decoder could not correct the chunk |
| err_index | input | 40 | Four 10-bit symbol indices; report k at bits 10k+9..10k |
| err_mask | input | 36 | Four 9-bit masks; report k at bits 9k+8..9k |
| busy | output | 1 | Patch job in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the index arithmetic. Symbols 1 and 8 hit the wrap of the bit offset, where a mapping without the one-symbol shift would flip the wrong bits. Symbol 456 straddles the end of the chunk: a design that wrote the high byte would corrupt byte 0 through address wrap-around. Indices 0, 457 and 1000 must leave the buffer untouched, and a design that misses the range test would damage low addresses. It also feeds overlapping reports, which expose a read-modify-write that reads stale data. It feeds counts of 0, 5 and the uncorrectable case, plus unused report slots holding live indices, to catch a patcher that ignores the count. Finally it checks the `done` latency, and it pokes the external port mid-job to catch a port that is not blocked.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2,
      ST_FIN   = 2'd3
   } rsp_state_t;

   localparam int WORD_W = 16;
endpackage

// File: rtl/rsp_byte_ram.sv
module rsp_byte_ram #(
   parameter int DEPTH  = 512,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic [AW-1:0]     a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic [AW-1:0]     b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              we_v    [2];
   logic [AW-1:0]     addr_v  [2];
   logic [DATA_W-1:0] wdata_v [2];
   logic [DATA_W-1:0] rdata_v [2];

   assign we_v[0]    = a_we;
   assign addr_v[0]  = a_addr;
   assign wdata_v[0] = a_wdata;
   assign we_v[1]    = b_we;
   assign addr_v[1]  = b_addr;
   assign wdata_v[1] = b_wdata;
   assign a_rdata    = rdata_v[0];
   assign b_rdata    = rdata_v[1];

   always_ff @(posedge clk) begin
      for (int q = 0; q < 2; q++) begin
         if (we_v[q]) mem[addr_v[q]] <= wdata_v[q];
         rdata_v[q] <= mem[addr_v[q]];
      end
   end

   // R7: the two halves of one patch never land on the same byte
   p_port_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we && b_we) |-> (a_addr != b_addr));
endmodule

// File: rtl/rsp_sym_locate.sv
module rsp_sym_locate #(
   parameter int CHUNK_BYTES = 512,
   parameter int SYM_W       = 9,
   parameter int IDX_W       = 10,
   localparam int AW         = $clog2(CHUNK_BYTES),
   localparam int PW         = IDX_W + 4,
   localparam int IW         = PW - 3
) (
   input  logic [IDX_W-1:0] sym_idx,
   output logic [AW-1:0]    lo_addr,
   output logic [AW-1:0]    hi_addr,
   output logic [2:0]       bit_off,
   output logic             in_range,
   output logic             hi_valid
);
   logic [PW-1:0] bitpos;
   logic [IW-1:0] raw_byte;
   logic [IW-1:0] upper;
   logic          on_boundary;

   assign bitpos      = PW'(sym_idx) * PW'(SYM_W);
   assign raw_byte    = bitpos[PW-1:3];
   assign on_boundary = (bitpos[2:0] == 3'd0);
   assign upper       = on_boundary ? (raw_byte - IW'(1)) : raw_byte;
   assign bit_off     = on_boundary ? 3'd7 : (bitpos[2:0] - 3'd1);
   assign in_range    = (sym_idx != '0) && (upper <= IW'(CHUNK_BYTES));
   assign hi_valid    = (upper < IW'(CHUNK_BYTES));
   assign lo_addr     = AW'(upper - IW'(1));
   assign hi_addr     = AW'(upper);
endmodule

// File: rtl/rsp_patch_alu.sv
module rsp_patch_alu #(
   parameter int SYM_W = 9
) (
   input  logic [7:0]       lo_in,
   input  logic [7:0]       hi_in,
   input  logic             hi_valid,
   input  logic [2:0]       bit_off,
   input  logic [SYM_W-1:0] mask,
   output logic [7:0]       lo_out,
   output logic [7:0]       hi_out
);
   import rsp_pkg::*;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] flip;
   logic [WORD_W-1:0] result;

   assign word   = {(hi_valid ? hi_in : 8'h00), lo_in};
   assign flip   = {{(WORD_W-SYM_W){1'b0}}, mask} << bit_off;
   assign result = word ^ flip;
   assign lo_out = result[7:0];
   assign hi_out = result[15:8];
endmodule

// File: rtl/rs_symbol_patcher.sv
module rs_symbol_patcher #(
   parameter int CHUNK_BYTES = 512,
   parameter int SYM_W       = 9,
   parameter int IDX_W       = 10,
   parameter int MAX_REPORTS = 4,
   parameter int CNT_W       = 3,
   localparam int AW         = $clog2(CHUNK_BYTES),
   localparam int RW         = (MAX_REPORTS > 1) ? $clog2(MAX_REPORTS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ext_we,
   input  logic [AW-1:0]                ext_addr,
   input  logic [7:0]                   ext_wdata,
   output logic [7:0]                   ext_rdata,
   input  logic                         start,
   input  logic [CNT_W-1:0]             err_count,
   input  logic                         uncorrectable,
   input  logic [MAX_REPORTS*IDX_W-1:0] err_index,
   input  logic [MAX_REPORTS*SYM_W-1:0] err_mask,
   output logic                         busy,
   output logic                         done
);
   import rsp_pkg::*;

   initial begin
      assert (SYM_W >= 2 && SYM_W <= 9) else $error("SYM_W must lie in 2..9");
      assert (CHUNK_BYTES == (1 << AW)) else $error("CHUNK_BYTES must be a power of two");
      assert ((1 << CNT_W) > MAX_REPORTS) else $error("CNT_W too narrow");
      assert (((1 << IDX_W) * SYM_W) / 8 > CHUNK_BYTES) else $error("IDX_W too narrow");
   end

   rsp_state_t                   st;
   logic [RW-1:0]                slot;
   logic [MAX_REPORTS*IDX_W-1:0] idx_q;
   logic [MAX_REPORTS*SYM_W-1:0] mask_q;
   logic [IDX_W-1:0]             idx_arr  [MAX_REPORTS];
   logic [SYM_W-1:0]             mask_arr [MAX_REPORTS];
   logic                         apply;

   for (genvar g = 0; g < MAX_REPORTS; g++) begin : g_unpack
      assign idx_arr[g]  = idx_q[g*IDX_W +: IDX_W];
      assign mask_arr[g] = mask_q[g*SYM_W +: SYM_W];
   end

   assign apply = !uncorrectable && (err_count != '0) &&
                  (err_count <= CNT_W'(MAX_REPORTS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         slot   <= '0;
         idx_q  <= '0;
         mask_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               idx_q  <= err_index;
               mask_q <= err_mask;
               slot   <= RW'(err_count - CNT_W'(1));
               st     <= apply ? ST_FETCH : ST_FIN;
            end
            ST_FETCH: st <= ST_STORE;
            ST_STORE: begin
               if (slot == '0) st <= ST_FIN;
               else begin
                  slot <= slot - RW'(1);
                  st   <= ST_FETCH;
               end
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
   assign done = (st == ST_FIN);

   logic [AW-1:0] lo_addr, hi_addr;
   logic [2:0]    bit_off;
   logic          in_range, hi_valid;

   rsp_sym_locate #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .SYM_W       (SYM_W),
      .IDX_W       (IDX_W)
   ) u_locate (
      .sym_idx  (idx_arr[slot]),
      .lo_addr  (lo_addr),
      .hi_addr  (hi_addr),
      .bit_off  (bit_off),
      .in_range (in_range),
      .hi_valid (hi_valid)
   );

   logic [7:0] lo_rd, hi_rd, lo_new, hi_new;

   rsp_patch_alu #(.SYM_W(SYM_W)) u_alu (
      .lo_in    (lo_rd),
      .hi_in    (hi_rd),
      .hi_valid (hi_valid),
      .bit_off  (bit_off),
      .mask     (mask_arr[slot]),
      .lo_out   (lo_new),
      .hi_out   (hi_new)
   );

   logic          wr_slot;
   logic          a_we, b_we;
   logic [AW-1:0] a_addr;
   logic [7:0]    a_wdata;

   assign wr_slot = (st == ST_STORE) && in_range;
   assign a_we    = busy ? wr_slot : ext_we;
   assign a_addr  = busy ? lo_addr : ext_addr;
   assign a_wdata = busy ? lo_new  : ext_wdata;
   assign b_we    = wr_slot && hi_valid;

   rsp_byte_ram #(.DEPTH(CHUNK_BYTES), .DATA_W(8)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_we    (a_we),
      .a_addr  (a_addr),
      .a_wdata (a_wdata),
      .a_rdata (lo_rd),
      .b_we    (b_we),
      .b_addr  (hi_addr),
      .b_wdata (hi_new),
      .b_rdata (hi_rd)
   );

   assign ext_rdata = lo_rd;

   // R8: completion is a single-cycle pulse
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: reports are walked downward, one fetch per store
   p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STORE && slot != '0) |=> (st == ST_FETCH && slot == $past(slot) - RW'(1)));
   // R6: an uncorrectable chunk goes straight to completion
   p_unc_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start && uncorrectable) |=> (st == ST_FIN));
   // R9: an accepted start makes the block busy on the next cycle
   p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);
   // R2: the high byte is never written for a field ending past the chunk
   p_no_hi_past_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      b_we |-> (hi_addr != '0));
endmodule

// File: tb/rs_symbol_patcher_test.sv
module rs_symbol_patcher_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_we = 1'b0;
   logic [8:0]  ext_addr = '0;
   logic [7:0]  ext_wdata = '0;
   logic [7:0]  ext_rdata;
   logic        start = 1'b0;
   logic [2:0]  err_count = '0;
   logic        uncorrectable = 1'b0;
   logic [39:0] err_index = '0;
   logic [35:0] err_mask = '0;
   logic        busy, done;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_mem [512];
   int r_idx [4];
   int r_mask [4];

   always #2 clk = ~clk;

   rs_symbol_patcher uut (
      .clk(clk), .rst_n(rst_n), .ext_we(ext_we), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .start(start),
      .err_count(err_count), .uncorrectable(uncorrectable),
      .err_index(err_index), .err_mask(err_mask), .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic model_flip(input int n, input int m);
      if (n == 0) return;
      for (int t = 0; t < 9; t++) begin
         int b;
         b = 9 * (n - 1) + t;
         if (m[t] && b < 4096) exp_mem[b >> 3][b & 7] = ~exp_mem[b >> 3][b & 7];
      end
   endtask

   task automatic load_all();
      for (int a = 0; a < 512; a++) begin
         @(negedge clk);
         ext_we = 1'b1; ext_addr = 9'(a); ext_wdata = 8'((a * 37 + 11) ^ (a >> 3));
         exp_mem[a] = 8'((a * 37 + 11) ^ (a >> 3));
      end
      @(negedge clk);
      ext_we = 1'b0;
   endtask

   task automatic verify_all(input string req);
      int bad = 0;
      int fa = 0;
      logic [7:0] fv = '0;
      for (int a = 0; a < 512; a++) begin
         @(negedge clk);
         ext_addr = 9'(a);
         @(posedge clk); #1;
         if (ext_rdata !== exp_mem[a]) begin
            if (bad == 0) begin fa = a; fv = ext_rdata; end
            bad++;
         end
      end
      check(bad == 0, $sformatf("%s buffer byte %0d", req, fa), int'(fv), int'(exp_mem[fa]));
   endtask

   task automatic run_patch(input int cnt, input bit unc, input bit poke, input string req);
      int c = (!unc && cnt >= 1 && cnt <= 4) ? cnt : 0;
      int lat = 0;
      for (int k = 0; k < c; k++) model_flip(r_idx[k], r_mask[k]);
      @(negedge clk);
      start = 1'b1; err_count = 3'(cnt); uncorrectable = unc;
      for (int k = 0; k < 4; k++) begin
         err_index[k*10 +: 10] = 10'(r_idx[k]);
         err_mask[k*9 +: 9] = 9'(r_mask[k]);
      end
      while (lat < 40) begin
         @(posedge clk); #1;
         lat++;
         if (lat == 1) begin
            start = 1'b0;
            check(busy === 1'b1, {req, " R9 busy after start"}, int'(busy), 1);
            if (poke) begin
               ext_we = 1'b1; ext_addr = 9'd300; ext_wdata = ~exp_mem[300];
            end
         end
         if (lat == 2) ext_we = 1'b0;
         if (done === 1'b1) break;
      end
      ext_we = 1'b0;
      check(lat == 2 * c + 1, {req, " R8 done latency"}, lat, 2 * c + 1);
      @(posedge clk); #1;
      check(done === 1'b0 && busy === 1'b0, {req, " R8 done one cycle, R9 busy drops"},
            int'({done, busy}), 0);
   endtask

   task automatic set_reports(input int i0, m0, i1, m1, i2, m2, i3, m3);
      r_idx[0] = i0; r_mask[0] = m0; r_idx[1] = i1; r_mask[1] = m1;
      r_idx[2] = i2; r_mask[2] = m2; r_idx[3] = i3; r_mask[3] = m3;
   endtask

   task automatic t_reset_r10();
      check(busy === 1'b0 && done === 1'b0, "R10 reset outputs", int'({busy, done}), 0);
      load_all();
      verify_all("R10 external load/readback");
   endtask

   task automatic t_mapping_r1();
      set_reports(1, 'h1FF, 0, 0, 0, 0, 0, 0);
      run_patch(1, 0, 0, "R1 symbol 1");
      verify_all("R1 symbol 1");
      set_reports(8, 'h155, 37, 'h0F3, 200, 'h101, 0, 0);
      run_patch(3, 0, 0, "R1 mixed symbols");
      verify_all("R1 mixed symbols");
   endtask

   task automatic t_end_r2();
      set_reports(456, 'h1FF, 455, 'h1A5, 0, 0, 0, 0);
      run_patch(2, 0, 0, "R2 chunk end");
      verify_all("R2 chunk end");
   endtask

   task automatic t_ignored_r3();
      set_reports(0, 'h1FF, 457, 'h1FF, 1000, 'h1FF, 0, 0);
      run_patch(3, 0, 0, "R3 out of range");
      verify_all("R3 out of range");
   endtask

   task automatic t_count_r4();
      set_reports(10, 'h0AA, 20, 'h155, 30, 'h1FF, 40, 'h1FF);
      run_patch(2, 0, 0, "R4 count limit");
      verify_all("R4 count limit");
   endtask

   task automatic t_bad_count_r5();
      set_reports(60, 'h1FF, 61, 'h1FF, 62, 'h1FF, 63, 'h1FF);
      run_patch(0, 0, 0, "R5 count zero");
      verify_all("R5 count zero");
      run_patch(5, 0, 0, "R5 count five");
      verify_all("R5 count five");
   endtask

   task automatic t_uncor_r6();
      set_reports(70, 'h1FF, 71, 'h1FF, 72, 'h1FF, 73, 'h1FF);
      run_patch(4, 1, 0, "R6 uncorrectable");
      verify_all("R6 uncorrectable");
   endtask

   task automatic t_overlap_r7();
      set_reports(50, 'h1C3, 51, 'h0FF, 51, 'h12C, 52, 'h1E1);
      run_patch(4, 0, 1, "R7 overlap with R9 poke");
      verify_all("R7 overlap, R9 blocked write");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset_r10();
      t_mapping_r1();
      t_end_r2();
      t_ignored_r3();
      t_count_r4();
      t_bad_count_r5();
      t_uncor_r6();
      t_overlap_r7();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule